// File: doc/BRIEF.md
# Busy-Gated Waveform Sequencer with Serial Register Port

This block is a register interface driven by a 3-wire serial bus (chip select, serial clock, data in). Through it a host loads two configuration bytes: a control byte that holds the charge-pump mode and the pump rise time, and a waveform byte that holds the output time. The host then writes a start command. The start command launches a self-timed sequence. In automatic pump mode the sequence has a pump-rise phase followed by a waveform phase. In manual mode only the waveform phase runs. The pump and the segment drivers are not part of the block; each one is represented only by how long its phase lasts.

The `busy` output is high for the whole sequence and doubles as the start flag. It drops by itself when the last phase ends. While `busy` is high, the block drops every configuration write and every further start command. A `phase` output reports the current phase, so the length of each phase can be measured from outside.

Top module: `wseq_ctrl`

## Requirements
- R1: A frame is the 16 data-line bits sampled on the first 16 rising serial-clock edges while `spi_cs_n` is low. The first 8 bits are the address, most significant bit first. The last 8 bits are the data, most significant bit first. Each low period of chip select carries at most one frame, and any edges after the 16th are ignored.
- R2: If chip select rises before the 16th rising clock edge, the frame is discarded and no register changes.
- R3: Address 0x00 writes the control byte. Its bit 7 selects automatic pump mode (1) or manual mode (0), and bits 6:0 give the rise time in units of 16 system clocks. Address 0x01 writes the waveform byte, which gives the output time in units of 16 system clocks.
- R4: A write to address 0x02 with data bit 0 set starts a sequence when `busy` is low. The same write with bit 0 clear has no effect.
- R5: In automatic mode, `phase` = 1 (pump rise) for rise×16 cycles, then `phase` = 2 (waveform) for wave×16 cycles. `busy` is high for the sum of the two.
- R6: In manual mode, no pump phase occurs and `busy` is high for wave×16 cycles.
- R7: When the last phase ends, `busy` falls and `phase` returns to 0 (idle) with no host action.
- R8: While `busy` is high, writes to addresses 0x00 and 0x01 and start commands are ignored.
- R9: A phase whose length field is zero is skipped. A start command for which every phase is zero leaves `busy` low.
- R10: After reset, `busy` is 0, `phase` is 0, and both configuration bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_sdi | input | 1 | Serial data in, asynchronous |
| busy | output | 1 | Sequence running; this is the start flag |
| phase | output | 2 | 0 idle, 1 pump rise, 2 waveform output |

## Verification
The hardest case to reach is a write that arrives while a sequence is running. It must leave no trace, yet the configuration bytes cannot be read back. To reach it, the stimulus starts a long automatic-mode sequence. While that sequence is still running, it sends new control and waveform values and a second start. It then starts the sequence again after the first one has finished and checks that the phase lengths still match the original bytes. Truncated frames are checked the same way, by their lack of effect on the next sequence.

// File: rtl/wseq_pkg.sv
// Shared types and address map for the waveform sequencer.
package wseq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PUMP = 2'd1,
        PH_WAVE = 2'd2
    } phase_t;

    localparam logic [7:0] ADDR_CTRL = 8'h00;
    localparam logic [7:0] ADDR_WAVE = 8'h01;
    localparam logic [7:0] ADDR_CMD  = 8'h02;
endpackage

// File: rtl/wseq_spi_rx.sv
// Serial frame receiver.
// Brings chip select, clock and data into the system clock domain through
// SYNC_STAGES flops each. While chip select is low, it shifts in the data bit
// on every rising serial-clock edge. After the last bit of an ADDR_W+DATA_W
// frame it pulses frame_valid for one cycle. Raising chip select clears the
// bit count, so a short frame never produces a pulse.
// Assumes that the serial clock runs several times slower than clk.
module wseq_spi_rx #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_sdi,
    output logic              frame_valid,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data
);
    localparam int unsigned FRAME_W = ADDR_W + DATA_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_W);

    logic [SYNC_STAGES-1:0] cs_sync, sck_sync, sdi_sync;
    logic                   sck_prev;
    logic [CNT_W-1:0]       bit_cnt;
    logic [FRAME_W-1:0]     shreg;
    logic                   cs_s, sck_s, sdi_s, sck_rise;

    // Synchronise the three bus lines and keep the previous clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sync  <= '1;
            sck_sync <= '0;
            sdi_sync <= '0;
            sck_prev <= 1'b0;
        end else begin
            cs_sync  <= {cs_sync[SYNC_STAGES-2:0], spi_cs_n};
            sck_sync <= {sck_sync[SYNC_STAGES-2:0], spi_sck};
            sdi_sync <= {sdi_sync[SYNC_STAGES-2:0], spi_sdi};
            sck_prev <= sck_s;
        end
    end

    // Select the synchronised line values and find the rising clock edge.
    always_comb begin
        cs_s     = cs_sync[SYNC_STAGES-1];
        sck_s    = sck_sync[SYNC_STAGES-1];
        sdi_s    = sdi_sync[SYNC_STAGES-1];
        sck_rise = sck_s & ~sck_prev;
    end

    // Shift in the frame bits and flag a complete frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shreg       <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (cs_s) begin
                bit_cnt <= '0;
            end else if (sck_rise && bit_cnt < FULL) begin
                shreg   <= {shreg[FRAME_W-2:0], sdi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) frame_valid <= 1'b1;
            end
        end
    end

    assign frame_addr = shreg[FRAME_W-1:DATA_W];
    assign frame_data = shreg[DATA_W-1:0];

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= FULL);
    a_r2_cs_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (bit_cnt == '0));
endmodule

// File: rtl/wseq_timer.sv
// Phase sequencer.
// On start, it runs the pump phase (automatic mode only) and then the
// waveform phase. Each phase lasts its length field times 2**TICK_LOG2
// cycles. A phase whose length is zero is skipped.
// Assumes that start is only asserted while the phase is idle, and that
// RISE_W is not larger than WAVE_W.
module wseq_timer
    import wseq_pkg::*;
#(
    parameter int unsigned RISE_W    = 7,
    parameter int unsigned WAVE_W    = 8,
    parameter int unsigned TICK_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              auto_mode,
    input  logic [RISE_W-1:0] rise_len,
    input  logic [WAVE_W-1:0] wave_len,
    output phase_t            phase
);
    localparam int unsigned CNT_W = WAVE_W + TICK_LOG2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rise_load, wave_load;
    logic             rise_nz, wave_nz;

    // Convert the length fields into terminal counts.
    always_comb begin
        rise_load = CNT_W'({rise_len, {TICK_LOG2{1'b0}}}) - 1'b1;
        wave_load = CNT_W'({wave_len, {TICK_LOG2{1'b0}}}) - 1'b1;
        rise_nz   = |rise_len;
        wave_nz   = |wave_len;
    end

    // Phase state and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    if (auto_mode && rise_nz) begin
                        phase <= PH_PUMP;
                        cnt   <= rise_load;
                    end else if (wave_nz) begin
                        phase <= PH_WAVE;
                        cnt   <= wave_load;
                    end
                end
                PH_PUMP: if (cnt == '0) begin
                    if (wave_nz) begin
                        phase <= PH_WAVE;
                        cnt   <= wave_load;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_WAVE: if (cnt == '0) phase <= PH_IDLE;
                         else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    a_r6_manual_no_pump: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start && !auto_mode) |=> (phase != PH_PUMP));
    a_r7_wave_not_back_to_pump: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAVE) |=> (phase != PH_PUMP));
    a_r9_zero_start_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start && !wave_nz && !(auto_mode && rise_nz)) |=> (phase == PH_IDLE));
endmodule

// File: rtl/wseq_ctrl.sv
// Top level of the waveform sequencer.
// Decodes the received serial frames into the control byte, the waveform
// byte and the start command. It drops all of them while a sequence is
// running, and exposes busy and the current phase.
// Assumes that chip select stays high for a gap between frames.
module wseq_ctrl
    import wseq_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned TICK_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_sdi,
    output logic       busy,
    output logic [1:0] phase
);
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned RISE_W = DATA_W - 1;

    logic              fv;
    logic [ADDR_W-1:0] faddr;
    logic [DATA_W-1:0] fdata;
    logic [DATA_W-1:0] ctrl_q, wave_q;
    logic              start;
    phase_t            ph;

    wseq_spi_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
        .frame_valid(fv), .frame_addr(faddr), .frame_data(fdata)
    );

    // Register writes; frames that arrive while busy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            wave_q <= '0;
        end else if (fv && !busy) begin
            if (faddr == ADDR_CTRL) ctrl_q <= fdata;
            if (faddr == ADDR_WAVE) wave_q <= fdata;
        end
    end

    // Decode the start command; it only acts while idle.
    always_comb start = fv && !busy && (faddr == ADDR_CMD) && fdata[0];

    wseq_timer #(.RISE_W(RISE_W), .WAVE_W(DATA_W), .TICK_LOG2(TICK_LOG2)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start),
        .auto_mode(ctrl_q[DATA_W-1]), .rise_len(ctrl_q[RISE_W-1:0]),
        .wave_len(wave_q), .phase(ph)
    );

    assign busy  = (ph != PH_IDLE);
    assign phase = ph;

    a_r8_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_q));
    a_r8_wave_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wave_q));
    a_r4_clear_bit_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (fv && !busy && faddr == ADDR_CMD && !fdata[0]) |=> !busy);
endmodule

// File: tb/sim_wseq_ctrl.sv
module sim_wseq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic busy;
    logic [1:0] phase;
    int checks = 0, fails = 0;
    int tot_busy = 0, tot_pump = 0, tot_wave = 0;
    int b0, p0, w0;

    always #2 clk = ~clk;

    wseq_ctrl u0 (.clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
                  .spi_sdi(sdi), .busy(busy), .phase(phase));

    // Running cycle totals per phase, sampled away from the active edge.
    always @(negedge clk) begin
        tot_busy <= tot_busy + (busy ? 1 : 0);
        tot_pump <= tot_pump + (phase == 2'd1 ? 1 : 0);
        tot_wave <= tot_wave + (phase == 2'd2 ? 1 : 0);
    end

    // Each entry is {control byte, waveform byte}.
    localparam logic [15:0] VEC [6] = '{16'h8203, 16'h0504, 16'h8100,
                                        16'h8002, 16'h0500, 16'hFF10};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nbits);
        logic [15:0] f;
        f = {a, d};
        @(negedge clk) cs_n = 1'b0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = f[15 - (i % 16)];
            sck = 1'b0;
            repeat (5) @(negedge clk);
            sck = 1'b1;
            repeat (5) @(negedge clk);
        end
        sck = 1'b0;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        repeat (260) @(negedge clk);
    endtask

    task automatic mark();
        @(negedge clk);
        b0 = tot_busy; p0 = tot_pump; w0 = tot_wave;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_and_check(input string req, input int exp_pump, input int exp_wave);
        mark();
        xfer(8'h02, 8'h01, 16);
        wait_idle();
        chk({req, " pump cycles"}, tot_pump - p0, exp_pump);
        chk({req, " wave cycles"}, tot_wave - w0, exp_wave);
        chk({req, " busy cycles"}, tot_busy - b0, exp_pump + exp_wave);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 busy after reset", busy, 0);
        chk("R10 phase after reset", phase, 0);
        // R10/R9: registers reset to zero, so start does nothing
        run_and_check("R10 start with reset regs", 0, 0);

        // R3 R5 R6 R9 R7: table walk
        foreach (VEC[i]) begin
            logic [7:0] c, w;
            int ep, ew;
            c = VEC[i][15:8];
            w = VEC[i][7:0];
            ep = c[7] ? 16 * int'(c[6:0]) : 0;
            ew = 16 * int'(w);
            xfer(8'h00, c, 16);
            xfer(8'h01, w, 16);
            run_and_check(c[7] ? "R5 auto" : "R6 manual", ep, ew);
            chk("R7 phase idle after run", phase, 0);
        end

        // R4: start with bit 0 clear, then set
        xfer(8'h00, 8'h81, 16);
        xfer(8'h01, 8'h01, 16);
        mark();
        xfer(8'h02, 8'h00, 16);
        wait_idle();
        chk("R4 bit0 clear no busy", tot_busy - b0, 0);
        run_and_check("R4 bit0 set", 16, 16);

        // R8: writes and a start during busy are ignored
        xfer(8'h00, 8'hFF, 16);
        xfer(8'h01, 8'h40, 16);
        mark();
        xfer(8'h02, 8'h01, 16);
        chk("R8 busy during lock test", busy, 1);
        xfer(8'h00, 8'h01, 16);
        xfer(8'h01, 8'h01, 16);
        xfer(8'h02, 8'h01, 16);
        wait_idle();
        chk("R8 busy length unchanged", tot_busy - b0, 2032 + 1024);
        run_and_check("R8 regs kept", 2032, 1024);

        // R2: truncated frames leave registers and command untouched
        xfer(8'h00, 8'h01, 10);
        xfer(8'h01, 8'h01, 15);
        mark();
        xfer(8'h02, 8'h01, 15);
        wait_idle();
        chk("R2 truncated start", tot_busy - b0, 0);
        run_and_check("R2 regs kept", 2032, 1024);

        // R1: bits past the 16th are ignored
        xfer(8'h00, 8'h02, 24);
        xfer(8'h01, 8'h01, 16);
        run_and_check("R1 extra bits ignored", 0, 16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule